// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set and Clear

This block is one general-purpose I/O port of parameterised width (eight pins by default), attached to a simple synchronous register bus. Software uses it to program each pin's direction and output level. A per-pin assignment register hands a pin over to an alternate peripheral function. In that case the peripheral's output enable and output value drive the pin in place of the port registers.

A single-cycle bus write updates the output data register in one of three ways: a plain store, a bit-set or a bit-clear. The set and clear addresses change only the bits written as 1, so one task can flip its own pins without reading back first. This means it cannot overwrite a bit that another task changed in between. The set address does a second job: a read there returns the live level of every pin, passed through a two-flop synchronizer. The read mux is combinational, so read data belongs to the address presented in the same cycle.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output data, direction and pin assignment registers all read 0, so every pin is a GPIO input and pin_oe is all zero.
- R2: While a pin's assignment bit is 0, its pin_oe bit equals its direction bit (1 = output) from the direction register at offset 0x04.
- R3: A write to offset 0x00 stores the write data in the output data register. While a pin's assignment bit is 0, its pin_out bit follows that register.
- R4: A read of offset 0x00 returns the stored output data register, whatever levels the pins carry.
- R5: A read of offset 0x08 returns the level of every pin, input or output. The level is taken through two flops, so a change on pin_in shows up in the read data two rising edges later.
- R6: A write to offset 0x08 sets each output data bit written as 1 and leaves bits written as 0 unchanged.
- R7: A write to offset 0x0C clears each output data bit written as 1 and leaves bits written as 0 unchanged. A read of offset 0x0C returns 0.
- R8: A pin whose bit in the assignment register at offset 0x10 is 1 takes its pin_oe from alt_oe and its pin_out from alt_out.
- R9: A write to any other offset changes no register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the current address (combinational) |
| pin_in | input | WIDTH | Levels sampled at the pads |
| pin_out | output | WIDTH | Output value for each pad |
| pin_oe | output | WIDTH | Output enable for each pad |
| alt_out | input | WIDTH | Output values from the alternate peripheral |
| alt_oe | input | WIDTH | Output enables from the alternate peripheral |

## Verification
Two cases are hard to reach from the ports. The first is a pin-data read that mixes driven and undriven pins. The second is seeing the synchronizer's exact latency. The bench models each pad: a pin loops back to pin_out when pin_oe is high and otherwise follows an external level that the bench drives. A read of offset 0x08 therefore returns a mix of register bits and outside levels, and the expected value is worked out bit by bit from the direction and assignment settings. For the latency, the bench changes the external level and reads at once, expecting the old value, and then reads again two edges later, expecting the new value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_DATA   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PINSET = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_ASSIGN = 5'h10;

  typedef enum logic [2:0] {
    RS_NONE, RS_DATA, RS_DIR, RS_PINSET, RS_CLR, RS_ASSIGN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
    case (a)
      OFF_DATA:   return RS_DATA;
      OFF_DIR:    return RS_DIR;
      OFF_PINSET: return RS_PINSET;
      OFF_CLR:    return RS_CLR;
      OFF_ASSIGN: return RS_ASSIGN;
      default:    return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] assign_q
);
  function automatic logic [WIDTH-1:0] bits_set(logic [WIDTH-1:0] cur, logic [WIDTH-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [WIDTH-1:0] bits_clear(logic [WIDTH-1:0] cur, logic [WIDTH-1:0] m);
    return cur & ~m;
  endfunction

  logic wr_data, wr_set, wr_clr, wr_dir, wr_assign, wr_unmapped;
  assign wr_data     = wr_en && (wr_sel == RS_DATA);
  assign wr_set      = wr_en && (wr_sel == RS_PINSET);
  assign wr_clr      = wr_en && (wr_sel == RS_CLR);
  assign wr_dir      = wr_en && (wr_sel == RS_DIR);
  assign wr_assign   = wr_en && (wr_sel == RS_ASSIGN);
  assign wr_unmapped = wr_en && (wr_sel == RS_NONE);

  logic [WIDTH-1:0] data_nxt;
  always_comb begin
    data_nxt = data_q;
    if (wr_data)     data_nxt = wdata;
    else if (wr_set) data_nxt = bits_set(data_q, wdata);
    else if (wr_clr) data_nxt = bits_clear(data_q, wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      assign_q <= '0;
    end else begin
      data_q <= data_nxt;
      if (wr_dir)    dir_q    <= wdata;
      if (wr_assign) assign_q <= wdata;
    end
  end

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wdata));
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> data_q == ($past(data_q) | $past(wdata)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> data_q == ($past(data_q) & ~$past(wdata)));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(data_q) && $stable(dir_q) && $stable(assign_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level_q
);
  logic [WIDTH-1:0] stage1_q;
  logic [1:0]       warm_q;
  logic             primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      level_q  <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      level_q  <= stage1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign primed = (warm_q == 2'd2);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> level_q == $past(pin_in, 2));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] assign_q,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_oe[i]  = assign_q[i] ? alt_oe[i]  : dir_q[i];
    assign pin_out[i] = assign_q[i] ? alt_out[i] : data_q[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  alt_oe
);
  reg_sel_e         acc_sel;
  logic             wr_en;
  logic [WIDTH-1:0] data_q, dir_q, assign_q, level_q;

  assign acc_sel = decode_addr(bus_addr);
  assign wr_en   = bus_sel && bus_wr;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(acc_sel), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .assign_q(assign_q)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level_q(level_q)
  );

  gpio_pinmux #(.WIDTH(WIDTH)) u_mux (
    .data_q(data_q), .dir_q(dir_q), .assign_q(assign_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    case (acc_sel)
      RS_DATA:   bus_rdata = data_q;
      RS_DIR:    bus_rdata = dir_q;
      RS_PINSET: bus_rdata = level_q;
      RS_ASSIGN: bus_rdata = assign_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bsel = 1'b0, bwr = 1'b0;
  logic [4:0]   baddr = '0;
  logic [W-1:0] bwdata = '0, brdata;
  logic [W-1:0] pin_in, pin_out, pin_oe;
  logic [W-1:0] alt_out = '0, alt_oe = '0;
  logic [W-1:0] ext_lvl = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_port #(.WIDTH(W)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr), .bus_addr(baddr),
    .bus_wdata(bwdata), .bus_rdata(brdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [W-1:0] d);
    @(posedge clk); #1;
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
    @(posedge clk); #1;
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, logic [W-1:0] exp, string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    bsel = 1'b1; bwr = 1'b0; baddr = a;
    @(posedge clk); #1;
    bsel = 1'b0;
  endtask

  task automatic check_pins(logic [W-1:0] e_oe, logic [W-1:0] e_out, string tag);
    @(posedge clk); #3;
    check({tag, " pin_oe"}, pin_oe, e_oe);
    check({tag, " pin_out"}, pin_out, e_out);
  endtask

  // Monitor: pops one expected item per read cycle
  always begin
    @(posedge clk); #3;
    if (bsel && !bwr) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard unexpected read actual=%02h expected=none", brdata);
      end else begin
        check(tag_q.pop_front(), brdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_read(5'h00, 8'h00, "R1 data reset");
    bus_read(5'h04, 8'h00, "R1 dir reset");
    bus_read(5'h10, 8'h00, "R1 assign reset");
    check_pins(8'h00, 8'h00, "R1");

    // R2 / R3 direction and store
    bus_write(5'h04, 8'h0F);
    bus_write(5'h00, 8'hA5);
    check_pins(8'h0F, 8'hA5, "R2 R3");
    bus_read(5'h00, 8'hA5, "R3 data readback");

    // R5 mixed pin read: low nibble driven, high from outside
    ext_lvl = 8'h3C;
    repeat (3) @(posedge clk);
    bus_read(5'h08, 8'h35, "R5 mixed pin read");

    // R6 set
    bus_write(5'h08, 8'h50);
    bus_read(5'h00, 8'hF5, "R6 set result");
    bus_write(5'h08, 8'h00);
    bus_read(5'h00, 8'hF5, "R6 zero set no change");

    // R7 clear
    bus_write(5'h0C, 8'h81);
    bus_read(5'h00, 8'h74, "R7 clear result");
    bus_read(5'h0C, 8'h00, "R7 clear reads zero");

    // R4 stored value independent of pins
    bus_write(5'h04, 8'h00);
    ext_lvl = 8'hC3;
    repeat (3) @(posedge clk);
    bus_read(5'h00, 8'h74, "R4 data vs pins");
    bus_read(5'h08, 8'hC3, "R5 all inputs");

    // R5 latency: change then read at once (old), again two edges on (new)
    @(posedge clk); #1 ext_lvl = 8'h5A;
    bus_read(5'h08, 8'hC3, "R5 before sync");
    bus_read(5'h08, 8'h5A, "R5 after sync");

    // R8 alternate function on top two pins
    bus_write(5'h04, 8'h0F);
    alt_oe = 8'hFF; alt_out = 8'h80;
    bus_write(5'h10, 8'hC0);
    bus_read(5'h10, 8'hC0, "R8 assign readback");
    check_pins(8'hCF, 8'hB4, "R8");
    alt_oe = 8'h40; alt_out = 8'h40;
    check_pins(8'h4F, 8'h74, "R8 alt change");

    // R9 unmapped offset
    bus_write(5'h14, 8'hFF);
    bus_write(5'h1C, 8'hFF);
    bus_read(5'h00, 8'h74, "R9 data unchanged");
    bus_read(5'h04, 8'h0F, "R9 dir unchanged");
    bus_read(5'h10, 8'hC0, "R9 assign unchanged");
    bus_read(5'h14, 8'h00, "R9 unmapped reads zero");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule